// File: doc/BRIEF.md
# Vector Element-Wise Execution Unit

This unit carries out one vector instruction over operands held in an external vector register file. After a start strobe it walks the element positions in order, one pair per clock. At each position it reads one element from source A and one from source B, and it does one of three kinds of work:

- it writes an element-wise sum or product to the destination vector;
- it sets one bit of a comparison mask;
- it folds the pair into a scalar accumulator, either as a plain sum of A or as a dot product of A and B.

Each source carries its own length. Positions past a source's length are padded by one of two policies. Zero padding makes missing elements read as zero. Invalid fill makes them carry an invalid marker that propagates into every result that touches them.

The register file is read combinationally. The unit drives the read index, and both sources' data and stored invalid bits come back in the same cycle. Destination writes come out on a write strobe with index, data and an invalid bit. The scalar result and its invalid flag are valid while done is high, and they hold until the next accepted start.

Control is a three-state machine:

- `S_IDLE` waits for start. Start goes to `S_RUN`, or straight to `S_FIN` when the run length is zero.
- `S_RUN` handles one element per cycle and moves to `S_FIN` after the last one.
- `S_FIN` raises done for one cycle and returns to `S_IDLE` unconditionally.

Top module: `vx_exec`

## Requirements
- R1: Operation code 0 (add) writes dst[i] = (A[i] + B[i]) mod 2^16 for every i below the run length n. The write for element i appears with wr_idx = i in the i-th cycle after the start edge (counting from 0).
- R2: Operation code 1 (multiply) writes the low 16 bits of the signed 16x16 product A[i]*B[i] for every i below n, with the same ordering as R1.
- R3: With pad_invalid = 0, an element at or beyond its source's length reads as zero. Stored invalid bits are ignored, and wr_inv and scalar_inv stay 0. An add therefore passes the longer vector's extra elements through, and a multiply zeroes them.
- R4: With pad_invalid = 1, an element is invalid if it is beyond its source's length or its stored invalid bit is set, and its data reads as zero. An add or multiply result is marked invalid (wr_inv = 1) when either input is invalid.
- R5: Operation code 2 (compare) makes no writes. It returns a 64-bit mask in scalar_out where bit i is 1 when A[i] < B[i] as signed values. In invalid-fill mode a bit is 0 if either input is invalid. Bits at or above n are 0.
- R6: Operation code 3 (accumulate) returns the sum of A[i] for i below n. The sum is signed, wraps at 32 bits, and is sign-extended to 64 bits. It makes no writes.
- R7: Operation code 4 (dot product) returns the sum of the signed products A[i]*B[i] for i below n. The sum wraps at 32 bits, is sign-extended to 64 bits, and makes no writes.
- R8: In invalid-fill mode, scalar_inv is 1 after an accumulate that met an invalid A element, or after a dot product that met an invalid element in either source. For all other operations scalar_inv is 0.
- R9: The run length n is the larger of the two clamped source lengths, and one element is processed per clock. Done is a one-cycle pulse n+1 cycles after the start edge, or 1 cycle after it when n = 0. Busy is high from the start edge through the done cycle.
- R10: A source length above 64 is treated as 64.
- R11: A start strobe while busy, including during the done cycle, is ignored. The running operation completes unchanged, and no new run follows.
- R12: After reset the unit is idle with busy, done and wr_en at 0 and scalar_out at 0.
- R13: Operation codes 5 to 7 run for n cycles like the others, but make no writes and return scalar_out = 0 and scalar_inv = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start strobe, taken only when idle |
| op_code | input | 3 | Operation select (0 add, 1 mul, 2 compare, 3 accumulate, 4 dot) |
| len_a | input | 7 | Element count of source A |
| len_b | input | 7 | Element count of source B |
| pad_invalid | input | 1 | 0 = zero padding, 1 = invalid fill |
| rd_idx | output | 6 | Element index read from both sources |
| rd_a_data | input | 16 | Source A element at rd_idx |
| rd_a_inv | input | 1 | Stored invalid bit of source A element |
| rd_b_data | input | 16 | Source B element at rd_idx |
| rd_b_inv | input | 1 | Stored invalid bit of source B element |
| wr_en | output | 1 | Destination element write strobe |
| wr_idx | output | 6 | Destination element index |
| wr_data | output | 16 | Destination element value |
| wr_inv | output | 1 | Destination element invalid bit |
| scalar_out | output | 64 | Compare mask or sign-extended reduction |
| scalar_inv | output | 1 | Reduction result invalid |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The delicate overlap is between the end of one instruction and the strobe that would begin the next. A start can land in the same cycle as done, or while the last elements are still streaming. The bench raises start together with a different operation and lengths in both places: once in the middle of a run and once exactly in the done cycle. It then judges the outcome at the ports. The first run's writes, done timing and scalar must match what is computed from the original operands. After the dropped strobe, busy, done and wr_en must stay low and scalar_out must not change.

// File: rtl/vx_pkg.sv
package vx_pkg;

    typedef enum logic [2:0] {
        OP_ADD = 3'd0,
        OP_MUL = 3'd1,
        OP_CMP = 3'd2,
        OP_SUM = 3'd3,
        OP_DOT = 3'd4
    } vx_op_e;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_RUN  = 2'd1,
        S_FIN  = 2'd2
    } vx_state_e;

endpackage

// File: rtl/vx_ctrl.sv
module vx_ctrl
    import vx_pkg::*;
#(
    parameter int NUM_ELEM = 64,
    parameter int LEN_W    = 7,
    parameter int IDX_W    = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [2:0]       op_code,
    input  logic [LEN_W-1:0] len_a,
    input  logic [LEN_W-1:0] len_b,
    input  logic             pad_invalid,
    output logic             launch,
    output logic             run,
    output logic             busy,
    output logic             done,
    output logic [IDX_W-1:0] idx,
    output vx_op_e           op_q,
    output logic             pad_q,
    output logic [LEN_W-1:0] len_a_q,
    output logic [LEN_W-1:0] len_b_q,
    output logic [LEN_W-1:0] len_n_q
);

    localparam logic [LEN_W-1:0] MAX_LEN = LEN_W'(NUM_ELEM);

    vx_state_e        state, state_nx;
    logic [LEN_W-1:0] a_cl, b_cl, n_cl;
    logic             last;

    // length clamping (R10) and run length as the larger source (R9)
    always_comb begin
        a_cl = (len_a > MAX_LEN) ? MAX_LEN : len_a;
        b_cl = (len_b > MAX_LEN) ? MAX_LEN : len_b;
        n_cl = (a_cl > b_cl) ? a_cl : b_cl;
    end

    // output decode
    always_comb begin
        launch = (state == S_IDLE) && start;
        run    = (state == S_RUN);
        busy   = (state != S_IDLE);
        done   = (state == S_FIN);
        last   = (LEN_W'(idx) == len_n_q - LEN_W'(1));
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE: if (start) state_nx = (n_cl == '0) ? S_FIN : S_RUN;
            S_RUN:  if (last)  state_nx = S_FIN;
            S_FIN:  state_nx = S_IDLE;
            default: state_nx = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // instruction latch and element index
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx     <= '0;
            op_q    <= OP_ADD;
            pad_q   <= 1'b0;
            len_a_q <= '0;
            len_b_q <= '0;
            len_n_q <= '0;
        end else if (launch) begin
            idx     <= '0;
            op_q    <= vx_op_e'(op_code);
            pad_q   <= pad_invalid;
            len_a_q <= a_cl;
            len_b_q <= b_cl;
            len_n_q <= n_cl;
        end else if (run && !last) begin
            idx <= idx + IDX_W'(1);
        end
    end

    // R9: done follows the last element by exactly one cycle
    a_r9_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_RUN && last) |=> done);

    // R9: one element per clock while running
    a_r9_idx_step: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_RUN && !last) |=> (idx == $past(idx) + IDX_W'(1)));

    // R11: an instruction in flight cannot be replaced
    a_r11_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (state != S_IDLE) |=> ($stable(op_q) && $stable(len_n_q) && $stable(pad_q)));

    // R10: latched run length never exceeds the vector size
    a_r10_len_clamped: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (len_n_q <= MAX_LEN));

endmodule

// File: rtl/vx_lane.sv
module vx_lane
    import vx_pkg::*;
#(
    parameter int ELEM_W = 16,
    parameter int LEN_W  = 7,
    parameter int IDX_W  = 6
) (
    input  logic [IDX_W-1:0]         idx,
    input  logic [LEN_W-1:0]         len_a_q,
    input  logic [LEN_W-1:0]         len_b_q,
    input  logic                     pad_q,
    input  vx_op_e                   op_q,
    input  logic [ELEM_W-1:0]        rd_a_data,
    input  logic                     rd_a_inv,
    input  logic [ELEM_W-1:0]        rd_b_data,
    input  logic                     rd_b_inv,
    output logic signed [ELEM_W-1:0] a_val,
    output logic signed [ELEM_W-1:0] b_val,
    output logic                     a_bad,
    output logic                     b_bad,
    output logic signed [2*ELEM_W-1:0] prod,
    output logic [ELEM_W-1:0]        elem_res,
    output logic                     elem_inv,
    output logic                     lt_bit
);

    logic a_in, b_in;

    always_comb begin
        a_in  = (LEN_W'(idx) < len_a_q);
        b_in  = (LEN_W'(idx) < len_b_q);
        a_val = a_in ? rd_a_data : '0;
        b_val = b_in ? rd_b_data : '0;
        // padding policy: invalid marks exist only in invalid-fill mode (R3, R4)
        a_bad = pad_q && (!a_in || rd_a_inv);
        b_bad = pad_q && (!b_in || rd_b_inv);
        prod  = a_val * b_val;
        if (op_q == OP_MUL) elem_res = prod[ELEM_W-1:0];
        else                elem_res = a_val + b_val;
        elem_inv = a_bad || b_bad;
        lt_bit   = !(a_bad || b_bad) && (a_val < b_val);
    end

endmodule

// File: rtl/vx_reduce.sv
module vx_reduce
    import vx_pkg::*;
#(
    parameter int NUM_ELEM = 64,
    parameter int ELEM_W   = 16,
    parameter int ACC_W    = 32,
    parameter int SC_W     = 64,
    parameter int IDX_W    = 6
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       launch,
    input  logic                       run,
    input  vx_op_e                     op_q,
    input  logic [IDX_W-1:0]           idx,
    input  logic signed [ELEM_W-1:0]   a_val,
    input  logic signed [2*ELEM_W-1:0] prod,
    input  logic                       a_bad,
    input  logic                       b_bad,
    input  logic                       lt_bit,
    output logic [SC_W-1:0]            scalar,
    output logic                       scalar_inv
);

    logic signed [ACC_W-1:0] acc, term_sum, term_dot;
    logic signed [SC_W-1:0]  acc_ext;
    logic [NUM_ELEM-1:0]     mask;
    logic                    taint;

    always_comb begin
        term_sum = ACC_W'(a_val);
        term_dot = ACC_W'(prod);
        acc_ext  = SC_W'(acc);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc   <= '0;
            taint <= 1'b0;
        end else if (launch) begin
            acc   <= '0;
            taint <= 1'b0;
        end else if (run) begin
            if (op_q == OP_SUM) begin
                acc   <= acc + term_sum;
                taint <= taint | a_bad;
            end else if (op_q == OP_DOT) begin
                acc   <= acc + term_dot;
                taint <= taint | a_bad | b_bad;
            end
        end
    end

    // one flop per mask position
    for (genvar g = 0; g < NUM_ELEM; g++) begin : g_mask
        logic bit_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                bit_q <= 1'b0;
            else if (launch)
                bit_q <= 1'b0;
            else if (run && op_q == OP_CMP && idx == IDX_W'(g))
                bit_q <= lt_bit;
        end
        assign mask[g] = bit_q;
    end

    always_comb begin
        scalar     = '0;
        scalar_inv = 1'b0;
        if (op_q == OP_CMP) begin
            scalar = SC_W'(mask);
        end else if (op_q == OP_SUM || op_q == OP_DOT) begin
            scalar     = acc_ext;
            scalar_inv = taint;
        end
    end

    // R6/R7: accumulator only moves during a running reduction
    a_r6_acc_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!launch && !(run && (op_q == OP_SUM || op_q == OP_DOT))) |=> $stable(acc));

    // R5: the mask only changes for a compare or a new launch
    a_r5_mask_only_cmp: assert property (@(posedge clk) disable iff (!rst_n)
        (!launch && op_q != OP_CMP) |=> $stable(mask));

endmodule

// File: rtl/vx_exec.sv
module vx_exec
    import vx_pkg::*;
#(
    parameter int NUM_ELEM = 64,
    parameter int ELEM_W   = 16,
    parameter int ACC_W    = 32,
    localparam int LEN_W   = $clog2(NUM_ELEM + 1),
    localparam int IDX_W   = $clog2(NUM_ELEM),
    localparam int SC_W    = (NUM_ELEM > ACC_W) ? NUM_ELEM : ACC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [2:0]        op_code,
    input  logic [LEN_W-1:0]  len_a,
    input  logic [LEN_W-1:0]  len_b,
    input  logic              pad_invalid,
    output logic [IDX_W-1:0]  rd_idx,
    input  logic [ELEM_W-1:0] rd_a_data,
    input  logic              rd_a_inv,
    input  logic [ELEM_W-1:0] rd_b_data,
    input  logic              rd_b_inv,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [ELEM_W-1:0] wr_data,
    output logic              wr_inv,
    output logic [SC_W-1:0]   scalar_out,
    output logic              scalar_inv,
    output logic              busy,
    output logic              done
);

    logic                       launch, run, pad_q, a_bad, b_bad, elem_inv, lt_bit;
    logic [IDX_W-1:0]           idx;
    vx_op_e                     op_q;
    logic [LEN_W-1:0]           len_a_q, len_b_q, len_n_q;
    logic signed [ELEM_W-1:0]   a_val, b_val;
    logic signed [2*ELEM_W-1:0] prod;
    logic [ELEM_W-1:0]          elem_res;

    vx_ctrl #(.NUM_ELEM(NUM_ELEM), .LEN_W(LEN_W), .IDX_W(IDX_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .op_code(op_code),
        .len_a(len_a), .len_b(len_b), .pad_invalid(pad_invalid),
        .launch(launch), .run(run), .busy(busy), .done(done), .idx(idx),
        .op_q(op_q), .pad_q(pad_q), .len_a_q(len_a_q), .len_b_q(len_b_q),
        .len_n_q(len_n_q)
    );

    vx_lane #(.ELEM_W(ELEM_W), .LEN_W(LEN_W), .IDX_W(IDX_W)) u_lane (
        .idx(idx), .len_a_q(len_a_q), .len_b_q(len_b_q), .pad_q(pad_q),
        .op_q(op_q), .rd_a_data(rd_a_data), .rd_a_inv(rd_a_inv),
        .rd_b_data(rd_b_data), .rd_b_inv(rd_b_inv), .a_val(a_val),
        .b_val(b_val), .a_bad(a_bad), .b_bad(b_bad), .prod(prod),
        .elem_res(elem_res), .elem_inv(elem_inv), .lt_bit(lt_bit)
    );

    vx_reduce #(.NUM_ELEM(NUM_ELEM), .ELEM_W(ELEM_W), .ACC_W(ACC_W),
                .SC_W(SC_W), .IDX_W(IDX_W)) u_reduce (
        .clk(clk), .rst_n(rst_n), .launch(launch), .run(run), .op_q(op_q),
        .idx(idx), .a_val(a_val), .prod(prod), .a_bad(a_bad), .b_bad(b_bad),
        .lt_bit(lt_bit), .scalar(scalar_out), .scalar_inv(scalar_inv)
    );

    always_comb begin
        rd_idx  = idx;
        wr_en   = run && (op_q == OP_ADD || op_q == OP_MUL);
        wr_idx  = idx;
        wr_data = elem_res;
        wr_inv  = elem_inv;
    end

    // R1: writes never land beyond the run length
    a_r1_wr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (LEN_W'(wr_idx) < len_n_q));

    // R3: zero-pad mode never produces an invalid element
    a_r3_zero_mode_clean: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !pad_q) |-> !wr_inv);

    // R5: compare mask is clear at and above the run length
    a_r5_mask_clean: assert property (@(posedge clk) disable iff (!rst_n)
        (done && op_q == OP_CMP) |-> ((scalar_out >> len_n_q) == '0));

    // R9: done is a single-cycle pulse
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

// File: tb/tb_vx_exec.sv
module tb_vx_exec;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  op_code = 3'd0;
    logic [6:0]  len_a = '0, len_b = '0;
    logic        pad_invalid = 1'b0;
    logic [5:0]  rd_idx;
    logic [15:0] rd_a_data, rd_b_data;
    logic        rd_a_inv, rd_b_inv;
    logic        wr_en, wr_inv, scalar_inv, busy, done;
    logic [5:0]  wr_idx;
    logic [15:0] wr_data;
    logic [63:0] scalar_out;

    logic [15:0] va [64];
    logic [15:0] vb [64];
    logic        ia [64];
    logic        ib [64];

    assign rd_a_data = va[rd_idx];
    assign rd_b_data = vb[rd_idx];
    assign rd_a_inv  = ia[rd_idx];
    assign rd_b_inv  = ib[rd_idx];

    vx_exec dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op_code(op_code),
        .len_a(len_a), .len_b(len_b), .pad_invalid(pad_invalid),
        .rd_idx(rd_idx), .rd_a_data(rd_a_data), .rd_a_inv(rd_a_inv),
        .rd_b_data(rd_b_data), .rd_b_inv(rd_b_inv), .wr_en(wr_en),
        .wr_idx(wr_idx), .wr_data(wr_data), .wr_inv(wr_inv),
        .scalar_out(scalar_out), .scalar_inv(scalar_inv), .busy(busy), .done(done)
    );

    always #10 clk = ~clk;

    int total = 0;
    int bad = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // expected results
    logic [15:0] e_d [64];
    logic        e_i [64];
    logic [63:0] e_sc;
    logic        e_si;
    int          e_n;

    task automatic model(input int op, input int la, input int lb, input bit pad);
        int ca, cb, acc;
        logic [63:0] mask;
        bit sinv;
        ca = (la > 64) ? 64 : la;
        cb = (lb > 64) ? 64 : lb;
        e_n = (ca > cb) ? ca : cb;
        acc = 0; mask = '0; sinv = 1'b0;
        for (int i = 0; i < 64; i++) begin
            logic [15:0] ea, eb;
            bit abad, bbad;
            int p;
            ea = (i < ca) ? va[i] : 16'h0;
            eb = (i < cb) ? vb[i] : 16'h0;
            abad = pad && ((i >= ca) || ia[i]);
            bbad = pad && ((i >= cb) || ib[i]);
            p = int'($signed(ea)) * int'($signed(eb));
            e_d[i] = (op == 1) ? p[15:0] : ea + eb;
            e_i[i] = abad | bbad;
            if (i < e_n) begin
                if (!(abad || bbad) && ($signed(ea) < $signed(eb))) mask[i] = 1'b1;
                if (op == 3) begin acc = acc + int'($signed(ea)); sinv = sinv | abad; end
                if (op == 4) begin acc = acc + p; sinv = sinv | abad | bbad; end
            end
        end
        if (op == 2)                 begin e_sc = mask; e_si = 1'b0; end
        else if (op == 3 || op == 4) begin e_sc = 64'(longint'(acc)); e_si = sinv; end
        else                         begin e_sc = '0; e_si = 1'b0; end
    endtask

    function automatic string op_tag(input int op);
        case (op)
            0: return "R1";
            1: return "R2";
            2: return "R5";
            3: return "R6";
            4: return "R7";
            default: return "R13";
        endcase
    endfunction

    task automatic fill_data();
        for (int i = 0; i < 64; i++) begin
            va[i] = 16'($urandom);
            vb[i] = 16'($urandom);
            ia[i] = (($urandom % 8) == 0);
            ib[i] = (($urandom % 8) == 0);
        end
        va[0] = 16'h7FFF; vb[0] = 16'h0001;
        va[1] = 16'h8000; vb[1] = 16'h8000;
        va[2] = 16'h0005; vb[2] = 16'h0005;
    endtask

    task automatic do_run(input int op, input int la, input int lb, input bit pad,
                          input bit poke_mid, input bit poke_done);
        logic [15:0] g_d [64];
        logic        g_i [64];
        int   k, wcount, dmis;
        bit   order_ok;
        string tag;
        logic [63:0] held;
        model(op, la, lb, pad);
        tag = $sformatf("%s %s%s", op_tag(op), pad ? "R4" : "R3",
                        (la > 64 || lb > 64) ? " R10" : "");
        for (int i = 0; i < 64; i++) begin g_d[i] = 'x; g_i[i] = 1'b0; end
        @(negedge clk);
        op_code = 3'(op); len_a = 7'(la); len_b = 7'(lb); pad_invalid = pad;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        k = 1; wcount = 0; order_ok = 1'b1;
        forever begin
            if (wr_en) begin
                if (int'(wr_idx) != k - 1) order_ok = 1'b0;
                g_d[wr_idx] = wr_data;
                g_i[wr_idx] = wr_inv;
                wcount++;
            end
            if (done) break;
            if (k > 200) break;
            if (poke_mid && k == 2) begin
                start = 1'b1; op_code = 3'd0; len_a = 7'd3; len_b = 7'd3; pad_invalid = ~pad;
            end
            if (k == 3) start = 1'b0;
            k++;
            @(negedge clk);
        end
        chk(k == e_n + 1, poke_mid ? "R9 R11" : "R9", {tag, " done cycle"}, 64'(k), 64'(e_n + 1));
        chk(busy === 1'b1, "R9", {tag, " busy at done"}, 64'(busy), 64'd1);
        chk(wcount == ((op <= 1) ? e_n : 0), op_tag(op), {tag, " write count"},
            64'(wcount), 64'((op <= 1) ? e_n : 0));
        if (op <= 1) begin
            dmis = 0;
            for (int i = 0; i < e_n; i++)
                if (g_d[i] !== e_d[i] || g_i[i] !== e_i[i]) dmis++;
            chk(dmis == 0 && order_ok, tag, " element mismatches", 64'(dmis), 64'd0);
        end
        chk(scalar_out === e_sc, tag, " scalar", scalar_out, e_sc);
        chk(scalar_inv === e_si, "R8", {tag, " scalar_inv"}, 64'(scalar_inv), 64'(e_si));
        if (poke_done) begin
            held = scalar_out;
            start = 1'b1; op_code = 3'd1; len_a = 7'd5; len_b = 7'd5;
            @(negedge clk);
            start = 1'b0;
            chk(!busy && !done && !wr_en, "R11", " start in done cycle launched",
                64'({busy, done, wr_en}), 64'd0);
            @(negedge clk);
            chk(!busy && !done && scalar_out === held, "R11", " idle after dropped start",
                scalar_out, held);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired: actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int las [8] = '{0, 1, 5, 3, 64, 64, 70, 2};
        int lbs [8] = '{0, 1, 3, 5, 64, 10, 2, 100};
        for (int i = 0; i < 64; i++) begin va[i] = '0; vb[i] = '0; ia[i] = 0; ib[i] = 0; end
        repeat (3) @(negedge clk);
        chk(!busy && !done && !wr_en && scalar_out == '0, "R12", "reset state",
            {busy, done, wr_en, scalar_out[60:0]}, 64'd0);
        rst_n = 1'b1;
        for (int op = 0; op < 6; op++)
            for (int pad = 0; pad < 2; pad++)
                for (int c = 0; c < 8; c++) begin
                    fill_data();
                    do_run(op, las[c], lbs[c], pad[0], 1'b0, 1'b0);
                end
        // overlap cases for R11
        fill_data();
        do_run(0, 20, 12, 1'b1, 1'b1, 1'b0);
        fill_data();
        do_run(4, 9, 16, 1'b0, 1'b1, 1'b1);
        fill_data();
        do_run(2, 7, 30, 1'b1, 1'b0, 1'b1);
        fill_data();
        do_run(3, 0, 0, 1'b0, 1'b0, 1'b1);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule